// File: doc/BRIEF.md
# GPIO Expander Interrupt Pin Controller

This block drives the two interrupt request pins of a two-port I/O expander with eight lines per port. A change-detect stage upstream pulses one flag per port when an enabled input line changes. The block latches each pulse as a pending interrupt for that port. The pending state stays up until the host performs the read chosen by the configuration: either a read of the port's capture register or a read of its live port-value register. Read strobes come from the register decoder, and each strobe is qualified per port.

An eight-bit configuration register controls how the pending state reaches the pins. Pins can be merged, so that both pins show the OR of both ports. A pin can be an open-drain output that pulls low or lets go, or an actively driven output whose active level is programmable. Each pin is brought out as a drive value plus an output-enable, so an open-drain pad can be modelled. The register also holds two addressing-mode bits that the bus side owns. They are stored and read back but have no effect here.

Top module: `gpx_int_ctrl`

## Requirements
- R1: After synchronous reset the configuration reads 0x00, no interrupt is pending, and both pins show the inactive level of push-pull active-low mode: int_drv = 2'b11, int_oe = 2'b11.
- R2: Configuration bits 4 and 3 always read 0 and writes to them are discarded. Bit 7 (bank mode) and bit 5 (sequential disable) are stored and read back but never change the pins.
- R3: A pulse on chg[i] marks port i pending at that clock edge. Port i stays pending until its selected clearing read occurs.
- R4: With configuration bit 0 (clear select) at 1, a pulse on rd_cap[i] clears only port i's pending state. A pulse on rd_port[i] has no effect on it.
- R5: With configuration bit 0 at 0, a pulse on rd_port[i] clears only port i's pending state. A pulse on rd_cap[i] has no effect on it.
- R6: When a change pulse and the selected clearing read for the same port arrive in the same cycle, the port ends up pending.
- R7: With configuration bit 6 (merge) at 0, pin 0 follows only port 0 and pin 1 follows only port 1. With bit 6 at 1, both pins are active when either port is pending.
- R8: With configuration bit 2 (open-drain) at 1, an active pin has int_oe = 1 and int_drv = 0. An inactive pin has int_oe = 0. The polarity bit is ignored.
- R9: With configuration bit 2 at 0, int_oe = 1 on both pins. int_drv equals configuration bit 1 (polarity, 1 = active-high) when the pin is active, and its inverse when the pin is inactive.
- R10: The pin outputs are registered. They show a change in pending state or configuration one clock edge after the edge that made the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read-back value |
| chg | input | 2 | Per-port change-detect pulse |
| rd_cap | input | 2 | Per-port capture-register read strobe |
| rd_port | input | 2 | Per-port port-value read strobe |
| int_drv | output | 2 | Interrupt pin drive value |
| int_oe | output | 2 | Interrupt pin output enable |

## Verification
The hardest case to reach is the one where a read of the unselected register type arrives while an interrupt is pending. The pins show nothing in that case, so the absence of a clear only becomes visible if the pins are unmerged and the other port's state is known. The stimulus walks every combination of merge, drive style, polarity and clear select, with the addressing bits and the discarded bits toggled alongside. Under each configuration it raises every pending pattern. It then issues both read types to each port in turn, and finally collides a change pulse with a clearing read. After each step the pins are sampled twice: once at the edge that updated the pending state, where the old pin value is expected, and once a cycle later.

// File: rtl/gpx_int_pkg.sv
package gpx_int_pkg;
  localparam int CFG_W = 8;
  localparam logic [CFG_W-1:0] CFG_KEEP = 8'hE7;

  typedef struct packed {
    logic bank;
    logic merge;
    logic seq_dis;
    logic rsv4;
    logic rsv3;
    logic odrain;
    logic pol_hi;
    logic clr_cap;
  } int_cfg_t;
endpackage

// File: rtl/gpx_int_cfg.sv
module gpx_int_cfg
  import gpx_int_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output int_cfg_t         cfg,
  output logic [CFG_W-1:0] rdata
);
  int_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q <= int_cfg_t'(wdata & CFG_KEEP);
    end
  end

  assign cfg   = cfg_q;
  assign rdata = cfg_q & CFG_KEEP;
endmodule

// File: rtl/gpx_int_pend.sv
module gpx_int_pend #(
  parameter int NPORT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_cap,
  input  logic [NPORT-1:0] chg,
  input  logic [NPORT-1:0] rd_cap,
  input  logic [NPORT-1:0] rd_port,
  output logic [NPORT-1:0] pend
);
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic clr;
    logic flag_q;

    assign clr = clr_cap ? rd_cap[i] : rd_port[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q <= 1'b0;
      end else if (chg[i]) begin
        flag_q <= 1'b1;
      end else if (clr) begin
        flag_q <= 1'b0;
      end
    end

    assign pend[i] = flag_q;
  end
endmodule

// File: rtl/gpx_int_pin.sv
module gpx_int_pin #(
  parameter int NPORT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] pend,
  input  logic             merge,
  input  logic             odrain,
  input  logic             pol_hi,
  output logic [NPORT-1:0] drv,
  output logic [NPORT-1:0] oe
);
  logic any_pend;
  assign any_pend = |pend;

  for (genvar i = 0; i < NPORT; i++) begin : g_pin
    logic act;
    logic drv_d, oe_d;
    logic drv_q, oe_q;

    assign act = merge ? any_pend : pend[i];

    always_comb begin
      if (odrain) begin
        drv_d = 1'b0;
        oe_d  = act;
      end else begin
        drv_d = act ? pol_hi : ~pol_hi;
        oe_d  = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        drv_q <= 1'b1;
        oe_q  <= 1'b1;
      end else begin
        drv_q <= drv_d;
        oe_q  <= oe_d;
      end
    end

    assign drv[i] = drv_q;
    assign oe[i]  = oe_q;
  end
endmodule

// File: rtl/gpx_int_ctrl.sv
module gpx_int_ctrl
  import gpx_int_pkg::*;
#(
  parameter int NPORT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic [NPORT-1:0] chg,
  input  logic [NPORT-1:0] rd_cap,
  input  logic [NPORT-1:0] rd_port,
  output logic [NPORT-1:0] int_drv,
  output logic [NPORT-1:0] int_oe
);
  int_cfg_t         cfg;
  logic [NPORT-1:0] pend;

  gpx_int_cfg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  gpx_int_pend #(.NPORT(NPORT)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .clr_cap (cfg.clr_cap),
    .chg     (chg),
    .rd_cap  (rd_cap),
    .rd_port (rd_port),
    .pend    (pend)
  );

  gpx_int_pin #(.NPORT(NPORT)) u_pin (
    .clk    (clk),
    .rst    (rst),
    .pend   (pend),
    .merge  (cfg.merge),
    .odrain (cfg.odrain),
    .pol_hi (cfg.pol_hi),
    .drv    (int_drv),
    .oe     (int_oe)
  );
endmodule

// File: rtl/gpx_int_ctrl_chk.sv
module gpx_int_ctrl_chk #(
  parameter int NPORT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       cfg_rdata,
  input logic [NPORT-1:0] chg,
  input logic [NPORT-1:0] rd_cap,
  input logic [NPORT-1:0] rd_port,
  input logic [NPORT-1:0] pend,
  input logic [NPORT-1:0] int_drv,
  input logic [NPORT-1:0] int_oe
);
  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[4:3] == 2'b00);

  assert_od_low_R8: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_rdata[2]) |-> (int_drv == '0));

  assert_pp_enabled_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_rdata[2]) |-> (int_oe == '1));

  assert_merge_equal_R7: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_rdata[6]) |-> (int_drv == {NPORT{int_drv[0]}} && int_oe == {NPORT{int_oe[0]}}));

  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
      chg[i] |=> pend[i]);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (pend[i] && !rd_cap[i] && !rd_port[i]) |=> pend[i]);

    assert_cap_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (cfg_rdata[0] && rd_cap[i] && !chg[i]) |=> !pend[i]);

    assert_port_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (!cfg_rdata[0] && rd_port[i] && !chg[i]) |=> !pend[i]);
  end
endmodule

bind gpx_int_ctrl gpx_int_ctrl_chk #(.NPORT(NPORT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_rdata (cfg_rdata),
  .chg       (chg),
  .rd_cap    (rd_cap),
  .rd_port   (rd_port),
  .pend      (pend),
  .int_drv   (int_drv),
  .int_oe    (int_oe)
);

// File: tb/test_gpx_int_ctrl.sv
module test_gpx_int_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [1:0] chg = '0;
  logic [1:0] rd_cap = '0;
  logic [1:0] rd_port = '0;
  logic [1:0] int_drv;
  logic [1:0] int_oe;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] m_cfg = '0;
  logic [1:0] m_pend = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpx_int_ctrl i_gpx_int_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .chg(chg), .rd_cap(rd_cap), .rd_port(rd_port),
    .int_drv(int_drv), .int_oe(int_oe)
  );

  // expected {drv[1:0], oe[1:0]} from configuration and pending state
  function automatic logic [3:0] pins(input logic [7:0] c, input logic [1:0] p);
    logic [1:0] d, o;
    for (int i = 0; i < 2; i++) begin
      logic a;
      a = c[6] ? (p[0] | p[1]) : p[i];
      if (c[2]) begin
        d[i] = 1'b0;
        o[i] = a;
      end else begin
        d[i] = a ? c[1] : ~c[1];
        o[i] = 1'b1;
      end
    end
    return {d, o};
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_pins(input string req, input logic [3:0] exp);
    check({int_drv, int_oe} === exp, req, {4'b0, int_drv, int_oe}, {4'b0, exp});
  endtask

  // one stimulus cycle, then the pins are checked at the setting edge (old) and one edge later (new)
  task automatic step(input logic [1:0] c, input logic [1:0] rc, input logic [1:0] rp, input string req);
    logic [3:0] old_pins;
    logic [1:0] clr;
    old_pins = pins(m_cfg, m_pend);
    chg = c; rd_cap = rc; rd_port = rp;
    @(posedge clk);
    clr = m_cfg[0] ? rc : rp;
    m_pend = c | (m_pend & ~clr);
    @(negedge clk);
    chg = '0; rd_cap = '0; rd_port = '0;
    check_pins("R10", old_pins);
    @(posedge clk);
    @(negedge clk);
    check_pins(req, pins(m_cfg, m_pend));
  endtask

  task automatic write_cfg(input logic [7:0] d);
    logic [3:0] old_pins;
    old_pins = pins(m_cfg, m_pend);
    cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk);
    m_cfg = d & 8'hE7;
    @(negedge clk);
    cfg_we = 1'b0;
    check(cfg_rdata === m_cfg, "R2", cfg_rdata, m_cfg);
    check_pins("R10", old_pins);
    @(posedge clk);
    @(negedge clk);
    check_pins("R7", pins(m_cfg, m_pend));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(cfg_rdata === 8'h00, "R1", cfg_rdata, 8'h00);
    check_pins("R1", 4'b1111);

    // R2: discarded bits and stored addressing bits
    write_cfg(8'h18);
    check(cfg_rdata === 8'h00, "R2", cfg_rdata, 8'h00);
    write_cfg(8'hFF);
    check(cfg_rdata === 8'hE7, "R2", cfg_rdata, 8'hE7);
    step(2'b00, 2'b11, 2'b11, "R2");

    for (int k = 0; k < 32; k++) begin
      logic [7:0] d;
      string clr_req;
      string pin_req;
      d = {k[4], k[3], k[4], k[4], k[4], k[2], k[1], k[0]};
      write_cfg(d);
      clr_req = d[0] ? "R4" : "R5";
      pin_req = d[2] ? "R8" : "R9";
      step(2'b00, 2'b11, 2'b11, clr_req);
      for (int pat = 1; pat < 4; pat++) begin
        step(pat[1:0], 2'b00, 2'b00, "R3");
        step(2'b00, 2'b00, 2'b00, d[6] ? "R7" : pin_req);
        for (int p = 0; p < 2; p++) begin
          logic [1:0] one;
          one = 2'b01 << p;
          // read of the unselected register type: no effect
          if (d[0]) step(2'b00, 2'b00, one, clr_req);
          else      step(2'b00, one, 2'b00, clr_req);
          // selected read clears this port only
          if (d[0]) step(2'b00, one, 2'b00, clr_req);
          else      step(2'b00, 2'b00, one, clr_req);
        end
        // set and selected clear collide: set wins
        if (d[0]) step(pat[1:0], 2'b11, 2'b00, "R6");
        else      step(pat[1:0], 2'b00, 2'b11, "R6");
        step(2'b00, 2'b11, 2'b11, "R3");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule